// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core whose register namespace slides with a window pointer. An instruction names one of 32 architectural registers with a 5-bit number. The block translates that number into a row of a larger physical array, using a registered window pointer and a registered global-bank level. Four groups of eight registers are visible at any time:

- a bank of globals, chosen by the level;
- three groups taken from a ring of window segments: outgoing, private and incoming.

Neighbouring windows overlap. The incoming group of one window is the same storage as the outgoing group of the window below it, so values pass between a caller and its callee without copying.

There are two combinational read ports and one clocked write port. Each read port also reports the physical row it resolved to. A clear input wipes the whole array. Pointer or level values beyond their range are folded back into range, and a flag reports the folding.

Top module: `winreg_file`

## Requirements
- R1: Architectural bits [4:3] pick the group (0 globals, 1 outgoing, 2 private, 3 incoming) and bits [2:0] the slot. A global register resolves to physical row level*8 + slot.
- R2: With base b = ((NWIN - ptr) mod NWIN) * 2, the three window groups use these segments: outgoing uses b, private uses b+1, and incoming uses (b+2) mod (2*NWIN). Segment s occupies rows NGL*8 + s*8 to NGL*8 + s*8 + 7.
- R3: The incoming group at pointer p holds the same data as the outgoing group at pointer (p-1) mod NWIN, including the wrap from pointer 0 to pointer NWIN-1.
- R4: Each global level is separate storage. A write to a global at one level is not seen at another level.
- R5: Read data and read rows follow the read address and the stored contents combinationally. A write becomes visible on the first read after the clock edge that takes it.
- R6: Pointer and level inputs are captured on the clock edge, and reads use the captured values. A write taken on the same edge as a change resolves through the previous mapping.
- R7: Writes to architectural register 0 are dropped, and reads of register 0 return zero.
- R8: A pointer input at or above NWIN, or a level input at or above NGL, is reduced modulo its range. The error flag is 1 in the cycle after such a value is captured and 0 after an in-range capture.
- R9: Asserting clear zeroes every global bank and every window segment on that edge, and takes priority over a write on the same edge.
- R10: After reset the pointer and level are 0, the error flag is 0 and all storage reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_in | input | $clog2(NWIN)+1 | Window pointer to capture |
| lvl_in | input | $clog2(NGL) | Global level to capture |
| clear | input | 1 | Zero the whole array on this edge |
| rd0_addr | input | 5 | Read port 0 architectural number |
| rd0_data | output | DW | Read port 0 data |
| rd0_row | output | $clog2(NGL*8+NWIN*16) | Read port 0 physical row |
| rd1_addr | input | 5 | Read port 1 architectural number |
| rd1_data | output | DW | Read port 1 data |
| rd1_row | output | $clog2(NGL*8+NWIN*16) | Read port 1 physical row |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural number |
| wr_data | input | DW | Write data |
| range_err | output | 1 | Previous capture was out of range |

## Verification
The bench writes through the outgoing group at one pointer and reads back through the incoming group at the next pointer, including the wrap at pointer 0. A wrong segment rotation would return zero or stale data there. It writes on the same edge that the pointer changes, and a design that applied the new mapping too early would put the value in the wrong window. It also covers the following cases:
- Register 0 is written, and a leak would show non-zero data on a later read.
- Clear arrives together with a write, and a missing priority would leave the written value behind.
- Out-of-range pointer and level values are captured, and a missing fold would give rows outside the array or a missing error flag.

// File: rtl/winreg_pkg.sv
// Package winreg_pkg: shared constants and the group encoding of the
// windowed register file. Assumes an architectural number of 5 bits.
package winreg_pkg;
    localparam int ARCH_W = 5;
    localparam int SLOT_W = 3;
    localparam int SLOTS  = 1 << SLOT_W;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_PRIV   = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;
endpackage

// File: rtl/winreg_ctx.sv
// Module winreg_ctx: captures the window pointer and global level,
// folds out-of-range values into range and flags them.
// Assumes NWIN >= 3 and NGL >= 2.
module winreg_ctx #(
    parameter int NWIN = 32,
    parameter int NGL  = 3,
    localparam int PW  = $clog2(NWIN),
    localparam int LW  = $clog2(NGL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW:0]   ptr_in,
    input  logic [LW-1:0] lvl_in,
    output logic [PW-1:0] ptr_q,
    output logic [LW-1:0] lvl_q,
    output logic          err_q
);
    logic [PW-1:0] ptr_fold;
    logic [LW-1:0] lvl_fold;
    logic          bad;

    // Fold the raw inputs into range and detect the out-of-range case.
    always_comb begin
        ptr_fold = PW'(32'(ptr_in) % NWIN);
        lvl_fold = LW'(32'(lvl_in) % NGL);
        bad      = (32'(ptr_in) >= NWIN) || (32'(lvl_in) >= NGL);
    end

    // Register the context used by the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            lvl_q <= '0;
            err_q <= 1'b0;
        end else begin
            ptr_q <= ptr_fold;
            lvl_q <= lvl_fold;
            err_q <= bad;
        end
    end
endmodule

// File: rtl/winreg_map.sv
// Module winreg_map: combinational translation of an architectural number
// to a physical row, given the captured pointer and level.
// Assumes the pointer and level are already in range.
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 32,
    parameter int NGL  = 3,
    localparam int PW  = $clog2(NWIN),
    localparam int LW  = $clog2(NGL),
    localparam int ROWS = NGL * SLOTS + 2 * NWIN * SLOTS,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic [ARCH_W-1:0] arch,
    input  logic [PW-1:0]     ptr,
    input  logic [LW-1:0]     lvl,
    output logic [RW-1:0]     row
);
    localparam int WIN_BASE = NGL * SLOTS;
    localparam int NSEG     = 2 * NWIN;

    grp_e        grp;
    logic [31:0] base_seg;
    logic [31:0] seg;
    logic [31:0] slot;

    // Pick the segment of the addressed group and form the row.
    always_comb begin
        grp      = grp_e'(arch[ARCH_W-1:SLOT_W]);
        slot     = 32'(arch[SLOT_W-1:0]);
        base_seg = (ptr == '0) ? 32'd0 : 32'((NWIN - 32'(ptr)) * 2);
        seg      = base_seg;
        unique case (grp)
            GRP_OUT:  seg = base_seg;
            GRP_PRIV: seg = base_seg + 32'd1;
            GRP_IN:   seg = (base_seg + 32'd2 == 32'(NSEG)) ? 32'd0 : base_seg + 32'd2;
            default:  seg = base_seg;
        endcase
        if (grp == GRP_GLOBAL)
            row = RW'(32'(lvl) * SLOTS + slot);
        else
            row = RW'(WIN_BASE + seg * SLOTS + slot);
    end
endmodule

// File: rtl/winreg_store.sv
// Module winreg_store: the physical array with one clocked write port,
// two combinational read ports and a whole-array clear.
// Assumes row indices are in range.
module winreg_store #(
    parameter int DW   = 32,
    parameter int ROWS = 536,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          we,
    input  logic [RW-1:0] wrow,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] rrow0,
    input  logic [RW-1:0] rrow1,
    output logic [DW-1:0] rdata0,
    output logic [DW-1:0] rdata1
);
    logic [DW-1:0] mem [ROWS];

    // Zero on reset or clear, otherwise take the write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wrow] <= wdata;
        end
    end

    // Combinational read of both ports.
    always_comb begin
        rdata0 = mem[rrow0];
        rdata1 = mem[rrow1];
    end
endmodule

// File: rtl/winreg_file.sv
// Module winreg_file: windowed integer register file top. Captures the
// context, maps three architectural ports to rows and wraps the array.
// Assumes register 0 is hard-wired to zero.
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 32,
    parameter int NGL  = 3,
    parameter int DW   = 32,
    localparam int PW  = $clog2(NWIN),
    localparam int LW  = $clog2(NGL),
    localparam int ROWS = NGL * SLOTS + 2 * NWIN * SLOTS,
    localparam int RW  = $clog2(ROWS),
    localparam int NPORT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW:0]       ptr_in,
    input  logic [LW-1:0]     lvl_in,
    input  logic              clear,
    input  logic [ARCH_W-1:0] rd0_addr,
    output logic [DW-1:0]     rd0_data,
    output logic [RW-1:0]     rd0_row,
    input  logic [ARCH_W-1:0] rd1_addr,
    output logic [DW-1:0]     rd1_data,
    output logic [RW-1:0]     rd1_row,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              range_err
);
    logic [PW-1:0]     ptr_q;
    logic [LW-1:0]     lvl_q;
    logic [ARCH_W-1:0] port_arch [NPORT];
    logic [RW-1:0]     port_row  [NPORT];
    logic [DW-1:0]     raw0, raw1;
    logic              wr_ok;

    winreg_ctx #(.NWIN(NWIN), .NGL(NGL)) u_ctx (
        .clk(clk), .rst_n(rst_n), .ptr_in(ptr_in), .lvl_in(lvl_in),
        .ptr_q(ptr_q), .lvl_q(lvl_q), .err_q(range_err)
    );

    // Gather the architectural numbers of the three ports.
    always_comb begin
        port_arch[0] = rd0_addr;
        port_arch[1] = rd1_addr;
        port_arch[2] = wr_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        winreg_map #(.NWIN(NWIN), .NGL(NGL)) u_map (
            .arch(port_arch[p]), .ptr(ptr_q), .lvl(lvl_q), .row(port_row[p])
        );
    end

    // Drop writes addressed to register 0.
    always_comb wr_ok = wr_en && (wr_addr != '0);

    winreg_store #(.DW(DW), .ROWS(ROWS)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .we(wr_ok),
        .wrow(port_row[2]), .wdata(wr_data),
        .rrow0(port_row[0]), .rrow1(port_row[1]),
        .rdata0(raw0), .rdata1(raw1)
    );

    // Drive the read outputs, forcing register 0 to zero.
    always_comb begin
        rd0_row  = port_row[0];
        rd1_row  = port_row[1];
        rd0_data = (rd0_addr == '0) ? '0 : raw0;
        rd1_data = (rd1_addr == '0) ? '0 : raw1;
    end
endmodule

// File: rtl/winreg_file_chk.sv
// Module winreg_file_chk: property checks on the register file ports,
// bound into every winreg_file instance.
module winreg_file_chk #(
    parameter int NWIN = 32,
    parameter int NGL  = 3,
    parameter int DW   = 32,
    localparam int PW  = $clog2(NWIN),
    localparam int LW  = $clog2(NGL),
    localparam int ROWS = NGL * 8 + 2 * NWIN * 8,
    localparam int RW  = $clog2(ROWS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW:0]   ptr_in,
    input logic [LW-1:0] lvl_in,
    input logic          clear,
    input logic [4:0]    rd0_addr,
    input logic [DW-1:0] rd0_data,
    input logic [RW-1:0] rd0_row,
    input logic          range_err
);
    // R8: an out-of-range capture raises the flag
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(ptr_in) >= NWIN) || (32'(lvl_in) >= NGL)) |=> range_err);

    // R8: an in-range capture clears the flag
    a_r8_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(ptr_in) < NWIN) && (32'(lvl_in) < NGL)) |=> !range_err);

    // R2: every resolved row lies inside the array
    a_r2_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rd0_row) < ROWS);

    // R1: globals resolve inside the global banks
    a_r1_global_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr[4:3] == 2'd0) |-> (32'(rd0_row) < NGL * 8));

    // R9: after a clear every read is zero
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd0_data == '0));

    // R7: register 0 reads as zero
    a_r7_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == 5'd0) |-> (rd0_data == '0));
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .NGL(NGL), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ptr_in(ptr_in), .lvl_in(lvl_in),
    .clear(clear), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd0_row(rd0_row), .range_err(range_err)
);

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb;
    localparam int N    = 32;
    localparam int NG   = 3;
    localparam int DW   = 32;
    localparam int ROWS = NG * 8 + 2 * N * 8;
    localparam int RW   = $clog2(ROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    ptr_in = '0;
    logic [1:0]    lvl_in = '0;
    logic          clear = 1'b0;
    logic [4:0]    rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [DW-1:0] rd0_data, rd1_data, wr_data = '0;
    logic [RW-1:0] rd0_row, rd1_row;
    logic          wr_en = 1'b0;
    logic          range_err;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] model [ROWS];
    int m_ptr = 0, m_lvl = 0;
    logic m_err = 1'b0;

    always #4 clk = ~clk;

    winreg_file #(.NWIN(N), .NGL(NG), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_in(ptr_in), .lvl_in(lvl_in),
        .clear(clear), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd0_row(rd0_row), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .rd1_row(rd1_row), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .range_err(range_err)
    );

    // Expected physical row from the mapping rules of R1 and R2.
    function automatic int exp_row(int a, int p, int l);
        int grp = a / 8;
        int slot = a % 8;
        int b = ((N - p) % N) * 2;
        case (grp)
            0: return l * 8 + slot;
            1: return NG * 8 + b * 8 + slot;
            2: return NG * 8 + (b + 1) * 8 + slot;
            default: return NG * 8 + ((b + 2) % (2 * N)) * 8 + slot;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive, update the model at the edge, then check reads.
    task automatic step(string tag, int p, int l, bit we, int wa,
                        logic [DW-1:0] wd, int ra0, int ra1, bit clr);
        int r0, r1;
        @(negedge clk);
        ptr_in = 6'(p); lvl_in = 2'(l); wr_en = we; wr_addr = 5'(wa);
        wr_data = wd; rd0_addr = 5'(ra0); rd1_addr = 5'(ra1); clear = clr;
        @(posedge clk);
        #1;
        if (clr) begin
            for (int i = 0; i < ROWS; i++) model[i] = '0;
        end else if (we && wa != 0) begin
            model[exp_row(wa, m_ptr, m_lvl)] = wd;
        end
        m_err = (p >= N) || (l >= NG);
        m_ptr = p % N;
        m_lvl = l % NG;
        r0 = exp_row(ra0, m_ptr, m_lvl);
        r1 = exp_row(ra1, m_ptr, m_lvl);
        chk({tag, " row0"}, int'(rd0_row), r0);
        chk({tag, " row1"}, int'(rd1_row), r1);
        chk({tag, " data0"}, int'(rd0_data), (ra0 == 0) ? 0 : int'(model[r0]));
        chk({tag, " data1"}, int'(rd1_data), (ra1 == 0) ? 0 : int'(model[r1]));
        chk({tag, " err"}, int'(range_err), int'(m_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R5 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < ROWS; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        step("R10 reset", 0, 0, 0, 0, 0, 8, 17, 0);
        // R7: register 0 writes dropped, reads zero
        step("R7 write0", 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 1, 0);
        step("R7 read0", 0, 0, 0, 0, 0, 0, 0, 0);
        // R4: global banks separate
        step("R4 wr g5", 0, 0, 1, 5, 32'h1111_0005, 5, 5, 0);
        step("R4 lvl1", 0, 1, 0, 0, 0, 5, 5, 0);
        step("R4 lvl0", 0, 0, 0, 0, 0, 5, 6, 0);
        // R3: outgoing of pointer 0 is incoming of pointer 1
        step("R3 wr out", 0, 0, 1, 11, 32'hA0A0_0011, 11, 12, 0);
        step("R3 ptr1", 1, 0, 0, 0, 0, 27, 11, 0);
        // R3: wrap, outgoing of pointer N-1 is incoming of pointer 0
        step("R3 goto31", N - 1, 0, 0, 0, 0, 12, 20, 0);
        step("R3 wr31", N - 1, 0, 1, 12, 32'hB0B0_0012, 12, 20, 0);
        step("R3 ptr0", 0, 0, 0, 0, 0, 28, 12, 0);
        // R6: write on the edge of a pointer change uses the old window
        step("R6 set", 4, 0, 0, 0, 0, 18, 18, 0);
        step("R6 chg+wr", 5, 0, 1, 18, 32'hC0C0_0018, 18, 18, 0);
        step("R6 back", 4, 0, 0, 0, 0, 18, 19, 0);
        // R5: write visible on the next read
        step("R5 wr", 4, 0, 1, 19, 32'hD0D0_0019, 19, 18, 0);
        step("R5 rd", 4, 0, 0, 0, 0, 19, 18, 0);
        // R8: out-of-range pointer and level fold with flag
        step("R8 ptr40", 40, 0, 0, 0, 0, 9, 25, 0);
        step("R8 lvl3", 2, 3, 0, 0, 0, 5, 3, 0);
        step("R8 back", 2, 1, 0, 0, 0, 5, 25, 0);
        // R1/R2: randomized mix
        for (int k = 0; k < 400; k++) begin
            step("R1R2 rand", int'($urandom_range(0, 63)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), $urandom,
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 0);
        end
        // R9: clear beats a same-edge write
        step("R9 pre", 3, 2, 1, 14, 32'hE0E0_0014, 14, 22, 0);
        step("R9 clear", 3, 2, 1, 14, 32'hF0F0_0014, 14, 30, 1);
        step("R9 after", 3, 2, 0, 0, 0, 14, 22, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule